// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Generation

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. It is purely combinational. One select input chooses among eight byte operations: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. Each operation takes two byte operands and the current flag byte. The block returns a byte result and a new flag byte that holds the zero, subtract, half-carry and carry flags.

A second, independent datapath adds two 16-bit register pairs. It has its own operand, sum and flag ports. A small condition evaluator reads the incoming flag byte and reports whether one of four branch conditions holds. Instruction decode, the register file, memory access and cycle timing are all outside this block.

Top module: `alu8_flags_unit`

## Requirements
- R1: With `op_sel` 0 (ADD) or 1 (ADC), `result_out` is the low byte of A+B, plus the incoming carry flag for ADC. The carry flag is bit 8 of the 9-bit sum. The subtract flag is 0.
- R2: With `op_sel` 2 (SUB) or 3 (SBC), `result_out` is the low byte of A-B, minus the incoming carry flag for SBC. The carry flag is 1 when the difference borrows (bit 8 of the 9-bit difference). The subtract flag is 1.
- R3: For ADD and ADC, the half-carry flag is 1 exactly when the low nibbles, together with any carry-in, carry out of bit 3.
- R4: For SUB, SBC and CP (`op_sel` 7), the half-carry flag is 1 exactly when the low nibble of A is smaller than the low nibble of B plus any borrow-in.
- R5: With `op_sel` 4 (AND), the result is A AND B. The half-carry flag is 1. The carry and subtract flags are 0.
- R6: With `op_sel` 5 (XOR) or 6 (OR), the result is A XOR B or A OR B. The half-carry, carry and subtract flags are all 0.
- R7: For every byte operation, the zero flag is 1 exactly when the computed byte is zero. For CP, the computed byte is the difference.
- R8: With `op_sel` 7 (CP), `result_out` equals A. The flags are the same as SUB would produce.
- R9: `pair_sum_out` is the low 16 bits of `pair_a_in + pair_b_in`. In `pair_flags_out`, the carry flag is bit 16 of the sum. The subtract flag is 0. The half-carry flag is the carry out of bit 11. The zero flag copies the incoming zero flag.
- R10: `cond_true` reports the condition chosen by `cond_sel`, read from `flags_in`: 0 means zero flag clear, 1 means zero flag set, 2 means carry flag clear, 3 means carry flag set.
- R11: Flag bytes use this layout: zero at bit 7, subtract at bit 6, half-carry at bit 5, carry at bit 4. Bits 3..0 of both output flag bytes always read 0. Bits 3..0 of `flags_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Byte operation select (encoding in R1, R2, R5, R6, R8) |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second byte operand |
| flags_in | input | 8 | Current flag byte |
| result_out | output | 8 | Byte result |
| flags_out | output | 8 | Updated flag byte for the byte operation |
| pair_a_in | input | 16 | First register-pair operand |
| pair_b_in | input | 16 | Second register-pair operand |
| pair_sum_out | output | 16 | 16-bit sum |
| pair_flags_out | output | 8 | Updated flag byte for the pair add |
| cond_sel | input | 2 | Branch condition select |
| cond_true | output | 1 | Selected condition holds |

## Verification
The embedded checks assume that every input is a known 0/1 value once it is sampled. They also assume that `op_sel` always names one of the eight defined operations, which holds because all eight 3-bit codes are defined. The stimulus drives every port from a deterministic generator shortly after a clock edge and leaves it stable until the following edge. It sets the low nibble of `flags_in` to arbitrary values so that the claim that those bits are ignored is exercised. It also cycles the incoming carry so that both the carry-in and borrow-in paths are covered.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CP  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;

  localparam int FLAG_BYTE_W = 8;
  localparam int BIT_Z = 7;
  localparam int BIT_N = 6;
  localparam int BIT_H = 5;
  localparam int BIT_C = 4;

  // half-carry lookup, index {a_bit, b_bit, r_bit}; bit i holds entry i
  localparam logic [7:0] HC_TBL_ADD = 8'hD4;
  localparam logic [7:0] HC_TBL_SUB = 8'h8E;

  function automatic logic hc_pick(input logic is_sub, input logic a_b,
                                   input logic b_b, input logic r_b);
    logic [2:0] idx;
    idx = {a_b, b_b, r_b};
    return is_sub ? HC_TBL_SUB[idx] : HC_TBL_ADD[idx];
  endfunction

  function automatic logic [FLAG_BYTE_W-1:0] pack_flags(input flag_t f);
    logic [FLAG_BYTE_W-1:0] v;
    v = '0;
    v[BIT_Z] = f.z;
    v[BIT_N] = f.n;
    v[BIT_H] = f.h;
    v[BIT_C] = f.c;
    return v;
  endfunction

  function automatic flag_t unpack_flags(input logic [FLAG_BYTE_W-1:0] v);
    flag_t f;
    f.z = v[BIT_Z];
    f.n = v[BIT_N];
    f.h = v[BIT_H];
    f.c = v[BIT_C];
    return f;
  endfunction

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
           (op == OP_SBC) || (op == OP_CP);
  endfunction

  function automatic logic is_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
  endfunction

endpackage

// File: rtl/alu8_byte_core.sv
module alu8_byte_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HC_POS = 3
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output flag_t             fl
);
  localparam int WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] cin_ext;
  logic [DATA_W-1:0] core_val;
  logic              sub_op;
  logic              arith_op;

  always_comb begin
    sub_op   = is_subtract(op);
    arith_op = is_arith(op);
    cin_ext  = '0;
    if (op == OP_ADC || op == OP_SBC) cin_ext[0] = carry_in;
    case (op)
      OP_ADD, OP_ADC:       wide = {1'b0, a} + {1'b0, b} + cin_ext;
      OP_SUB, OP_SBC, OP_CP: wide = {1'b0, a} - {1'b0, b} - cin_ext;
      OP_AND:               wide = {1'b0, a & b};
      OP_XOR:               wide = {1'b0, a ^ b};
      default:              wide = {1'b0, a | b};
    endcase
    core_val = wide[DATA_W-1:0];
    res      = (op == OP_CP) ? a : core_val;
    fl.z     = (core_val == '0);
    fl.n     = sub_op;
    fl.h     = arith_op ? hc_pick(sub_op, a[HC_POS], b[HC_POS], core_val[HC_POS])
                        : (op == OP_AND);
    fl.c     = arith_op ? wide[DATA_W] : 1'b0;
  end

endmodule

// File: rtl/alu8_pair_adder.sv
module alu8_pair_adder
  import alu8_pkg::*;
#(
  parameter int PAIR_W = 16,
  parameter int HC_POS = 11
) (
  input  logic [PAIR_W-1:0] a,
  input  logic [PAIR_W-1:0] b,
  input  logic              z_keep,
  output logic [PAIR_W-1:0] sum,
  output flag_t             fl
);
  logic [PAIR_W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[PAIR_W-1:0];
    fl.z = z_keep;
    fl.n = 1'b0;
    fl.h = hc_pick(1'b0, a[HC_POS], b[HC_POS], sum[HC_POS]);
    fl.c = wide[PAIR_W];
  end

endmodule

// File: rtl/alu8_cond_eval.sv
module alu8_cond_eval (
  input  logic [1:0] sel,
  input  logic       z_flag,
  input  logic       c_flag,
  output logic       holds
);
  logic picked;

  always_comb begin
    picked = sel[1] ? c_flag : z_flag;
    holds  = sel[0] ? picked : ~picked;
  end

endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 16,
  parameter int HC_POS = 3
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] result_out,
  output logic [7:0]        flags_out,
  input  logic [PAIR_W-1:0] pair_a_in,
  input  logic [PAIR_W-1:0] pair_b_in,
  output logic [PAIR_W-1:0] pair_sum_out,
  output logic [7:0]        pair_flags_out,
  input  logic [1:0]        cond_sel,
  output logic              cond_true
);
  localparam int PAIR_HC_POS = PAIR_W - DATA_W + HC_POS;

  alu_op_e op_e;
  flag_t   fin;
  flag_t   byte_fl;
  flag_t   pair_fl;
  logic    unused_low_flags;

  assign op_e             = alu_op_e'(op_sel);
  assign fin              = unpack_flags(flags_in);
  assign unused_low_flags = ^flags_in[3:0];

  alu8_byte_core #(.DATA_W(DATA_W), .HC_POS(HC_POS)) core_i (
    .op       (op_e),
    .a        (a_in),
    .b        (b_in),
    .carry_in (fin.c),
    .res      (result_out),
    .fl       (byte_fl)
  );

  alu8_pair_adder #(.PAIR_W(PAIR_W), .HC_POS(PAIR_HC_POS)) pair_i (
    .a      (pair_a_in),
    .b      (pair_b_in),
    .z_keep (fin.z),
    .sum    (pair_sum_out),
    .fl     (pair_fl)
  );

  alu8_cond_eval cond_i (
    .sel    (cond_sel),
    .z_flag (fin.z),
    .c_flag (fin.c),
    .holds  (cond_true)
  );

  assign flags_out      = pack_flags(byte_fl);
  assign pair_flags_out = pack_flags(pair_fl);

  always_comb begin
    assert_low_nibble_zero_R11: assert (flags_out[3:0] == 4'h0 && pair_flags_out[3:0] == 4'h0)
      else $error("low flag nibble not zero");
    assert_logic_no_carry_R6: assert (!(op_e == OP_XOR || op_e == OP_OR) ||
                                      (!byte_fl.c && !byte_fl.n && !byte_fl.h))
      else $error("xor/or flags not cleared");
    assert_and_half_R5: assert (op_e != OP_AND || (byte_fl.h && !byte_fl.c && !byte_fl.n))
      else $error("and flags wrong");
    assert_cp_keeps_a_R8: assert (op_e != OP_CP || result_out == a_in)
      else $error("compare altered result");
    assert_sub_sets_n_R2: assert (!(op_e == OP_SUB || op_e == OP_SBC) || byte_fl.n)
      else $error("subtract flag missing");
    assert_pair_zero_kept_R9: assert (pair_flags_out[BIT_Z] == flags_in[BIT_Z] &&
                                      !pair_flags_out[BIT_N])
      else $error("pair add zero/subtract wrong");
    assert_zero_result_R7: assert (op_e == OP_CP || (flags_out[BIT_Z] == (result_out == '0)))
      else $error("zero flag mismatch");
  end

endmodule

// File: tb/alu8_flags_unit_tb_top.sv
module alu8_flags_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [7:0]  a_in = '0, b_in = '0, flags_in = '0;
  logic [7:0]  result_out, flags_out, pair_flags_out;
  logic [15:0] pair_a_in = '0, pair_b_in = '0, pair_sum_out;
  logic [1:0]  cond_sel = '0;
  logic        cond_true;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  int unsigned seed = 32'h1357_9BDF;

  always #4 clk = ~clk;

  alu8_flags_unit dut_i (
    .op_sel(op_sel), .a_in(a_in), .b_in(b_in), .flags_in(flags_in),
    .result_out(result_out), .flags_out(flags_out),
    .pair_a_in(pair_a_in), .pair_b_in(pair_b_in),
    .pair_sum_out(pair_sum_out), .pair_flags_out(pair_flags_out),
    .cond_sel(cond_sel), .cond_true(cond_true)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // behavioural reference model, plain integer arithmetic
  task automatic model_and_check();
    int a, b, cy, r, res, h, c, n, z, zin, pa, pb, ps;
    string ctag, htag;
    a = a_in; b = b_in; cy = flags_in[4]; zin = flags_in[7];
    h = 0; c = 0; n = 0;
    case (op_sel)
      0: begin r = a + b;      h = ((a%16)+(b%16)) > 15;      ctag = "R1"; htag = "R3"; end
      1: begin r = a + b + cy; h = ((a%16)+(b%16)+cy) > 15;   ctag = "R1"; htag = "R3"; end
      2: begin r = a - b;      h = (a%16) < (b%16);           ctag = "R2"; htag = "R4"; n = 1; end
      3: begin r = a - b - cy; h = (a%16) < ((b%16)+cy);      ctag = "R2"; htag = "R4"; n = 1; end
      4: begin r = a & b; h = 1;                              ctag = "R5"; htag = "R5"; end
      5: begin r = a ^ b;                                     ctag = "R6"; htag = "R6"; end
      6: begin r = a | b;                                     ctag = "R6"; htag = "R6"; end
      default: begin r = a - b; h = (a%16) < (b%16);          ctag = "R8"; htag = "R4"; n = 1; end
    endcase
    if (op_sel < 4 || op_sel == 7) c = (r < 0) || (r > 255);
    res = r & 255;
    z = (res == 0);
    chk(result_out == ((op_sel == 7) ? a : res), ctag, result_out, (op_sel == 7) ? a : res);
    chk(flags_out[7] == z, "R7 zero", flags_out[7], z);
    chk(flags_out[6] == n, {ctag, " subtract"}, flags_out[6], n);
    chk(flags_out[4] == c, {ctag, " carry"}, flags_out[4], c);
    chk(flags_out[5] == h, {htag, " half"}, flags_out[5], h);
    chk(flags_out[3:0] == 0 && pair_flags_out[3:0] == 0, "R11 low nibble",
        {flags_out[3:0], pair_flags_out[3:0]}, 0);
    pa = pair_a_in; pb = pair_b_in; ps = pa + pb;
    chk(pair_sum_out == (ps & 16'hFFFF), "R9 sum", pair_sum_out, ps & 16'hFFFF);
    chk(pair_flags_out[7:4] == {zin[0], 1'b0, ((pa%4096)+(pb%4096)) > 4095, ps > 65535},
        "R9 flags", pair_flags_out[7:4],
        {zin[0], 1'b0, ((pa%4096)+(pb%4096)) > 4095, ps > 65535});
    case (cond_sel)
      0: chk(cond_true == !zin, "R10 NZ", cond_true, !zin);
      1: chk(cond_true == zin,  "R10 Z",  cond_true, zin);
      2: chk(cond_true == !cy,  "R10 NC", cond_true, !cy);
      default: chk(cond_true == cy, "R10 C", cond_true, cy);
    endcase
  endtask

  task automatic apply(input int op, input int a, input int b, input int f,
                       input int pa, input int pb, input int cs);
    @(posedge clk); #1;
    op_sel = op[2:0]; a_in = a[7:0]; b_in = b[7:0]; flags_in = f[7:0];
    pair_a_in = pa[15:0]; pair_b_in = pb[15:0]; cond_sel = cs[1:0];
    @(negedge clk);
    model_and_check();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        done = 1;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give ADD 0+0
    @(negedge clk);
    chk(result_out == 0 && flags_out == 8'h80, "R1 reset", {result_out, flags_out}, 16'h0080);
    // directed corners
    apply(0, 8'h0F, 8'h01, 8'h00, 16'h0FFF, 16'h0001, 0); // R3 half carry, R9 bit-11 carry
    apply(0, 8'hFF, 8'h01, 8'h0F, 16'hFFFF, 16'h0001, 1); // R1 carry + R7 zero, R11 low nibble junk
    apply(1, 8'hFF, 8'h00, 8'h10, 16'h8000, 16'h8000, 3); // R1 ADC carry-in
    apply(2, 8'h10, 8'h01, 8'h80, 16'h0000, 16'h0000, 0); // R4 nibble borrow, R9 Z kept
    apply(2, 8'h00, 8'h01, 8'h00, 16'h1234, 16'h4321, 2); // R2 borrow
    apply(3, 8'h01, 8'h00, 8'h10, 16'hF000, 16'h1000, 3); // R2 SBC to zero
    apply(3, 8'h10, 8'h0F, 8'h1A, 16'h00FF, 16'h0001, 2); // R4 borrow-in at nibble
    apply(4, 8'hF0, 8'h0F, 8'hF0, 16'h0800, 16'h0800, 1); // R5 zero AND
    apply(5, 8'hAA, 8'hAA, 8'hF0, 16'h0001, 16'h0001, 0); // R6 XOR zero
    apply(6, 8'h00, 8'h00, 8'hFF, 16'hFFFF, 16'hFFFF, 2); // R6 OR zero
    apply(7, 8'h42, 8'h42, 8'h00, 16'h0000, 16'h0000, 1); // R8 compare equal
    apply(7, 8'h03, 8'h14, 8'h10, 16'h0000, 16'h0000, 3); // R8 compare borrow
    // pseudo-random sweep over every operation
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 150; k++) begin
        int unsigned x, y;
        x = nxt(); y = nxt();
        apply(op, x[7:0], x[15:8], x[31:24], y[15:0], y[31:16], x[17:16]);
      end
    end
    done = 1;
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule